// File: doc/BRIEF.md
# Banked Translation Entry Store with Replicated Read Ports

This block holds a small table of address translation entries. Each entry is one word: a physical page number in the upper bits and a set of permission bits in the lower bits. The table is split into several banks. A read names one entry by index. The upper index bits pick the bank and the lower bits pick the row inside every bank. All banks are looked up combinationally in the request cycle, and every bank's word is captured in its own register. In the following cycle a late multiplexer picks the register of the requested bank. It places that word on several identical output copies, so that separate consumers each get their own private copy.

One write port updates a single entry per cycle. When a write and a read target the same entry in the same cycle, the write data is forwarded into the read result, so the reader never sees a stale word. When no read is requested, the outputs keep the last read result. Replacement choice and tag matching are outside the block.

Top module: `xlat_bank_store`

## Requirements
- R1: While reset is asserted and right after it is released, `rsp_valid` is 0 and every output copy of page number and permissions is 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `rd_en` = 1, and 0 in the cycle after a cycle with `rd_en` = 0.
- R3: A read of an entry returns the page number and permissions most recently written to that entry in an earlier cycle.
- R4: When `wr_en` and `rd_en` are both 1 and `wr_idx` equals `rd_idx`, the read result is the data being written in that same cycle.
- R5: A write to a different index in the same cycle as a read leaves that read's result unchanged. This includes an index in the same row of another bank.
- R6: Copy k of the result lies at bits [k*PN_W +: PN_W] of `rsp_ppn` and at bits [k*PERM_W +: PERM_W] of `rsp_perm`, and all copies are equal in every cycle.
- R7: The bank is given by the upper log2(NUM_BANKS) bits of the index and the row by the remaining lower bits. Entries that share a row in different banks are stored separately.
- R8: In a cycle after one with `rd_en` = 0, the outputs hold the previous read result unchanged.
- R9: After reset every entry reads back as 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Entry index to read (bank in upper bits) |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Entry index to write |
| wr_ppn | input | PN_W | Page number to write |
| wr_perm | input | PERM_W | Permission bits to write |
| rsp_valid | output | 1 | Read result valid, one cycle after the request |
| rsp_ppn | output | NUM_COPIES*PN_W | Replicated page number copies |
| rsp_perm | output | NUM_COPIES*PERM_W | Replicated permission copies |

## Verification
A full sweep of reads over a freshly reset table separates correct reset contents from leftovers. A full write-then-read sweep with a distinct word per index shows whether the bank and row split is decoded correctly, since a swapped or truncated field returns another index's word. Same-cycle write and read on the same index, spread across every bank boundary, separates a working bypass from a stale array read. Same-cycle writes to the same row in other banks catch bypass logic that ignores the bank. Idle cycles placed between reads show whether the outputs hold or drift, and every copy is compared against the scoreboard on every cycle.

// File: rtl/xlat_store_pkg.sv
package xlat_store_pkg;

  // Width of an index that selects one of n items (at least one bit).
  function automatic int unsigned sel_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Number of rows each bank holds.
  function automatic int unsigned rows_per_bank(input int unsigned entries,
                                                input int unsigned banks);
    return entries / banks;
  endfunction

endpackage

// File: rtl/xlat_store_bank.sv
module xlat_store_bank #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic              rd_load,
  output logic [DATA_W-1:0] rd_q,
  output logic              bypass_o
);

  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_word;

  // Same-cycle write to the looked-up row wins over the stored word.
  always_comb begin
    bypass_o = wr_hit && (wr_row == rd_row);
    rd_word  = bypass_o ? wr_data : mem[rd_row];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_hit) begin
      mem[wr_row] <= wr_data;
    end
  end

  // Per-bank result register, loaded only on a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= rd_word;
  end

endmodule

// File: rtl/xlat_store_fanout.sv
module xlat_store_fanout #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COPIES = 3
) (
  input  logic [BANKS*DATA_W-1:0]  bank_q,
  input  logic [BANK_W-1:0]        sel,
  output logic [COPIES*DATA_W-1:0] dup
);

  logic [DATA_W-1:0] bank_arr [BANKS];
  logic [DATA_W-1:0] chosen;

  for (genvar b = 0; b < BANKS; b++) begin : g_unpack
    assign bank_arr[b] = bank_q[b*DATA_W +: DATA_W];
  end

  assign chosen = bank_arr[sel];

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    assign dup[k*DATA_W +: DATA_W] = chosen;
  end

endmodule

// File: rtl/xlat_bank_store.sv
module xlat_bank_store
  import xlat_store_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned PN_W        = 24,
  parameter int unsigned PERM_W      = 8,
  parameter int unsigned NUM_COPIES  = 3,
  localparam int unsigned IDX_W      = sel_bits(NUM_ENTRIES),
  localparam int unsigned BANK_W     = sel_bits(NUM_BANKS),
  localparam int unsigned ROWS       = rows_per_bank(NUM_ENTRIES, NUM_BANKS),
  localparam int unsigned ROW_W      = IDX_W - BANK_W,
  localparam int unsigned DATA_W     = PN_W + PERM_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [PN_W-1:0]              wr_ppn,
  input  logic [PERM_W-1:0]            wr_perm,
  output logic                         rsp_valid,
  output logic [NUM_COPIES*PN_W-1:0]   rsp_ppn,
  output logic [NUM_COPIES*PERM_W-1:0] rsp_perm
);

  function automatic logic [BANK_W-1:0] bank_of(input logic [IDX_W-1:0] idx);
    return idx[IDX_W-1 -: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [IDX_W-1:0] idx);
    return idx[ROW_W-1:0];
  endfunction

  logic [BANK_W-1:0]            wr_bank;
  logic [BANK_W-1:0]            rd_bank;
  logic [ROW_W-1:0]             wr_row;
  logic [ROW_W-1:0]             rd_row;
  logic [DATA_W-1:0]            wr_word;
  logic [NUM_BANKS-1:0]         wr_bank_hit;
  logic [NUM_BANKS-1:0]         bypass_vec;
  logic [NUM_BANKS*DATA_W-1:0]  bank_q;
  logic [NUM_COPIES*DATA_W-1:0] dup;
  logic [BANK_W-1:0]            rd_bank_q;
  logic                         valid_q;

  assign wr_bank = bank_of(wr_idx);
  assign rd_bank = bank_of(rd_idx);
  assign wr_row  = row_of(wr_idx);
  assign rd_row  = row_of(rd_idx);
  assign wr_word = {wr_ppn, wr_perm};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wr_bank_hit[b] = wr_en && (wr_bank == BANK_W'(b));

    xlat_store_bank #(
      .ROWS   (ROWS),
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W)
    ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_bank_hit[b]),
      .wr_row   (wr_row),
      .wr_data  (wr_word),
      .rd_row   (rd_row),
      .rd_load  (rd_en),
      .rd_q     (bank_q[b*DATA_W +: DATA_W]),
      .bypass_o (bypass_vec[b])
    );
  end

  // Bank select travels with the data so the late mux uses the read-cycle index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) rd_bank_q <= rd_bank;
    end
  end

  xlat_store_fanout #(
    .BANKS  (NUM_BANKS),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W),
    .COPIES (NUM_COPIES)
  ) fanout_i (
    .bank_q (bank_q),
    .sel    (rd_bank_q),
    .dup    (dup)
  );

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_split
    assign rsp_ppn[k*PN_W +: PN_W]      = dup[k*DATA_W + PERM_W +: PN_W];
    assign rsp_perm[k*PERM_W +: PERM_W] = dup[k*DATA_W +: PERM_W];
  end

  assign rsp_valid = valid_q;

endmodule

// File: rtl/xlat_bank_store_chk.sv
module xlat_bank_store_chk #(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned PN_W       = 24,
  parameter int unsigned PERM_W     = 8,
  parameter int unsigned NUM_COPIES = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_en,
  input logic [IDX_W-1:0]             rd_idx,
  input logic                         wr_en,
  input logic [IDX_W-1:0]             wr_idx,
  input logic [PN_W-1:0]              wr_ppn,
  input logic [PERM_W-1:0]            wr_perm,
  input logic                         rsp_valid,
  input logic [NUM_COPIES*PN_W-1:0]   rsp_ppn,
  input logic [NUM_COPIES*PERM_W-1:0] rsp_perm,
  input logic [NUM_BANKS-1:0]         bypass_vec
);

  // R2
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  // R2
  no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

  // R4
  bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && (wr_idx == rd_idx)) |=>
      ((rsp_ppn[PN_W-1:0] == $past(wr_ppn)) && (rsp_perm[PERM_W-1:0] == $past(wr_perm))));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rsp_ppn) && $stable(rsp_perm)));

  // R5
  single_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bypass_vec));

  // R5
  bypass_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bypass_vec) |-> wr_en);

endmodule

bind xlat_bank_store xlat_bank_store_chk #(
  .IDX_W      (IDX_W),
  .NUM_BANKS  (NUM_BANKS),
  .PN_W       (PN_W),
  .PERM_W     (PERM_W),
  .NUM_COPIES (NUM_COPIES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_idx     (rd_idx),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_ppn     (wr_ppn),
  .wr_perm    (wr_perm),
  .rsp_valid  (rsp_valid),
  .rsp_ppn    (rsp_ppn),
  .rsp_perm   (rsp_perm),
  .bypass_vec (bypass_vec)
);

// File: tb/xlat_bank_store_tb.sv
module xlat_bank_store_tb_top;

  localparam int ENTRIES = 32;
  localparam int BANKS   = 4;
  localparam int ROWS    = ENTRIES / BANKS;
  localparam int PN_W    = 24;
  localparam int PERM_W  = 8;
  localparam int COPIES  = 3;
  localparam int IDX_W   = 5;

  typedef struct {
    bit                 valid;
    logic [PN_W-1:0]    ppn;
    logic [PERM_W-1:0]  perm;
    string              tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [PN_W-1:0] wr_ppn = '0;
  logic [PERM_W-1:0] wr_perm = '0;
  logic rsp_valid;
  logic [COPIES*PN_W-1:0] rsp_ppn;
  logic [COPIES*PERM_W-1:0] rsp_perm;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;

  exp_t sb_q[$];
  logic [PN_W-1:0]   m_ppn  [ENTRIES];
  logic [PERM_W-1:0] m_perm [ENTRIES];
  logic [PN_W-1:0]   last_ppn  = '0;
  logic [PERM_W-1:0] last_perm = '0;

  always #4 clk = ~clk;

  xlat_bank_store dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
    .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
  );

  function automatic logic [PN_W-1:0] pat_ppn(input int i, input int salt);
    return PN_W'(24'h3C0000 ^ (i * 24'h010203) ^ (salt * 24'h0F0F0F));
  endfunction

  function automatic logic [PERM_W-1:0] pat_perm(input int i, input int salt);
    return PERM_W'(i * 37 + 1 + salt * 91);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushing the expected result for the next cycle.
  task automatic step(input bit rd, input int ridx, input bit wr, input int widx,
                      input logic [PN_W-1:0] wp, input logic [PERM_W-1:0] wm,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rd_en   = rd;
    rd_idx  = IDX_W'(ridx);
    wr_en   = wr;
    wr_idx  = IDX_W'(widx);
    wr_ppn  = wp;
    wr_perm = wm;
    if (rd) begin
      if (wr && (widx == ridx)) begin
        last_ppn  = wp;
        last_perm = wm;
      end else begin
        last_ppn  = m_ppn[ridx];
        last_perm = m_perm[ridx];
      end
    end
    e.valid = rd;
    e.ppn   = last_ppn;
    e.perm  = last_perm;
    e.tag   = tag;
    sb_q.push_back(e);
    if (wr) begin
      m_ppn[widx]  = wp;
      m_perm[widx] = wm;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, 1'b0, 0, '0, '0, tag);
  endtask

  // Monitor: compares every output copy with the scoreboard after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_valid == e.valid, "R2", {e.tag, " valid"},
              64'(rsp_valid), 64'(e.valid));
        for (int k = 0; k < COPIES; k++) begin
          check(rsp_ppn[k*PN_W +: PN_W] == e.ppn, e.tag, $sformatf("R6 ppn copy %0d", k),
                64'(rsp_ppn[k*PN_W +: PN_W]), 64'(e.ppn));
          check(rsp_perm[k*PERM_W +: PERM_W] == e.perm, e.tag, $sformatf("R6 perm copy %0d", k),
                64'(rsp_perm[k*PERM_W +: PERM_W]), 64'(e.perm));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_ppn[i]  = '0;
      m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(rsp_valid == 1'b0, "R1", "valid in reset", 64'(rsp_valid), 64'd0);
    check(rsp_ppn == '0, "R1", "ppn in reset", 64'(rsp_ppn[PN_W-1:0]), 64'd0);
    check(rsp_perm == '0, "R1", "perm in reset", 64'(rsp_perm[PERM_W-1:0]), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(rsp_valid == 1'b0, "R1", "valid after reset", 64'(rsp_valid), 64'd0);
    mon_on = 1'b1;

    // R9: every entry reads zero before any write
    for (int i = 0; i < ENTRIES; i++) step(1'b1, i, 1'b0, 0, '0, '0, "R9");

    // R3/R7: fill with distinct words (idle reads also check R8 hold)
    for (int i = 0; i < ENTRIES; i++)
      step(1'b0, 0, 1'b1, i, pat_ppn(i, 0), pat_perm(i, 0), "R8");
    for (int i = 0; i < ENTRIES; i++) step(1'b1, i, 1'b0, 0, '0, '0, "R3");

    // R7: same row across banks, interleaved order
    for (int r = 0; r < ROWS; r++)
      for (int b = BANKS - 1; b >= 0; b--)
        step(1'b1, b * ROWS + r, 1'b0, 0, '0, '0, "R7");

    // R4: same-cycle write and read of one index, incl. bank edges
    for (int i = 0; i < ENTRIES; i += 3)
      step(1'b1, i, 1'b1, i, pat_ppn(i, 1), pat_perm(i, 1), "R4");
    step(1'b1, ROWS - 1, 1'b1, ROWS - 1, pat_ppn(7, 2), pat_perm(7, 2), "R4");
    step(1'b1, ROWS, 1'b1, ROWS, pat_ppn(8, 2), pat_perm(8, 2), "R4");
    step(1'b1, ENTRIES - 1, 1'b1, ENTRIES - 1, pat_ppn(31, 2), pat_perm(31, 2), "R4");

    // R5: write same row other bank, and other row same bank
    for (int i = 0; i < ENTRIES; i += 5) begin
      step(1'b1, i, 1'b1, (i + ROWS) % ENTRIES, pat_ppn(i, 3), pat_perm(i, 3), "R5");
      step(1'b1, i, 1'b1, (i / ROWS) * ROWS + ((i + 1) % ROWS), pat_ppn(i, 4), pat_perm(i, 4), "R5");
    end

    // R8: idle gaps between reads, then R3 readback of updated table
    for (int i = 0; i < ENTRIES; i += 4) begin
      step(1'b1, i, 1'b0, 0, '0, '0, "R3");
      idle("R8");
      idle("R8");
    end
    for (int i = 0; i < ENTRIES; i++) step(1'b1, i, 1'b0, 0, '0, '0, "R3");

    idle("R8");
    idle("R8");
    @(posedge clk);
    #3;
    check(sb_q.size() == 0, "R2", "scoreboard drained", 64'(sb_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule